// File: doc/BRIEF.md
# I2C Controller Interrupt and Status Unit

This block holds the interrupt and status state of an I2C controller that has both a master engine and a slave engine. The engines report single-cycle event pulses. The master engine reports transaction done, NACK received and arbitration lost. The slave engine reports receive request, transmit request and first byte received. The block turns these pulses into sticky raw bits, per-side error and request flags, and one interrupt line for each side.

Software reaches the state through a simple request/write-enable bus with a registered read path. Each side has three registers:

- a mask register, which gates that side's interrupt line;
- a raw status register, which can always be read;
- a write-one-to-clear register.

A slave data register passes the received byte through to software and hands a transmit byte to the slave engine. Reading or writing it retires the matching request flags. The I2C shift logic, bit timing and pads sit outside this block.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, every raw bit, mask bit, error flag and slave request flag is 0, both interrupt outputs are low, and every register reads 0 while m_busy_i is low.
- R2: A pulse on m_done_i, m_nack_i or m_arb_lost_i sets the master raw bit on the next clock edge. The raw bit reads at address 2, bit 0.
- R3: The master status register (address 0) reads {arb_lost, nack, error, busy} in bits 3..0. Busy follows m_busy_i. Error sets on a NACK or an arbitration loss, and nack and arb_lost record which cause occurred. All three flags hold until an m_start_i pulse clears them, and a cause arriving in the same cycle as m_start_i wins.
- R4: m_irq_o equals the master raw bit AND the master mask bit. s_irq_o equals the slave raw bit AND the slave mask bit. The masks are bit 0 of address 1 (master) and address 5 (slave), and both can be read back.
- R5: The raw bits at address 2 (master) and address 6 (slave) read their true value whatever the mask holds.
- R6: Writing a word with bit 0 set to address 3 (master) or address 7 (slave) clears that side's raw bit. Writing bit 0 as 0 leaves the raw bit unchanged.
- R7: When an event and a clear write for the same side land in the same cycle, the raw bit stays set.
- R8: The slave status register (address 4) reads {fbr, treq, rreq} in bits 2..0. s_rx_req_i sets rreq, s_tx_req_i sets treq, and s_rx_req_i together with s_first_byte_i also sets fbr in the same edge.
- R9: A read of address 8 returns s_rx_data_i and clears rreq and fbr. A write to address 8 clears treq, loads s_tx_data_o and pulses s_tx_load_o for one cycle. A request event in the same cycle wins over the clear.
- R10: Master events never change the slave raw bit or s_irq_o, and slave events never change the master raw bit or m_irq_o.
- R11: Read data appears on rdata_o one cycle after the read request, reflecting the state before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| m_busy_i | input | 1 | Master engine busy level |
| m_start_i | input | 1 | Master transaction start pulse |
| m_done_i | input | 1 | Master transaction done pulse |
| m_nack_i | input | 1 | Slave did not acknowledge pulse |
| m_arb_lost_i | input | 1 | Arbitration lost pulse |
| s_rx_req_i | input | 1 | Slave receive request pulse |
| s_tx_req_i | input | 1 | Slave transmit request pulse |
| s_first_byte_i | input | 1 | First byte of transfer, qualifies s_rx_req_i |
| s_rx_data_i | input | DATA_W | Byte received by slave engine |
| s_tx_data_o | output | DATA_W | Byte for slave engine to send |
| s_tx_load_o | output | 1 | One-cycle strobe for s_tx_data_o |
| m_irq_o | output | 1 | Master interrupt line |
| s_irq_o | output | 1 | Slave interrupt line |

## Verification
Some behaviours are checked by assertions on every cycle:

- every event sets its raw bit on the following edge, even against a clear;
- a clear write with no competing event empties the raw bit;
- the error flag sets on either cause and falls only after a start pulse;
- fbr never stands without rreq;
- a rising slave line always traces back to a slave event or a slave mask write.

Other behaviours only the bench's scenarios can show. These are the register read layout and the one-cycle read latency, the side effects of slave data register accesses, and write-zero having no effect. The bench exercises them through long random event and bus traffic compared against a bench model, plus directed same-cycle collisions.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  typedef enum logic [3:0] {
    RA_MSTAT = 4'd0,
    RA_MMASK = 4'd1,
    RA_MRAW  = 4'd2,
    RA_MCLR  = 4'd3,
    RA_SSTAT = 4'd4,
    RA_SMASK = 4'd5,
    RA_SRAW  = 4'd6,
    RA_SCLR  = 4'd7,
    RA_SDATA = 4'd8
  } reg_addr_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_M    = 0;
  localparam int unsigned SIDE_S    = 1;

  typedef struct packed {
    logic arb_lost;
    logic nack;
    logic err;
  } m_stat_t;

  typedef struct packed {
    logic fbr;
    logic treq;
    logic rreq;
  } s_stat_t;

endpackage

// File: rtl/i2c_irq_line.sv
module i2c_irq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);

  logic raw_q, mask_q;

  // event has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (evt_i) raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;

endmodule

// File: rtl/i2c_mst_err.sv
module i2c_mst_err
  import i2c_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    nack_i,
  input  logic    arb_lost_i,
  input  logic    start_i,
  output m_stat_t stat_o
);

  m_stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      if (nack_i || arb_lost_i) stat_q.err <= 1'b1;
      else if (start_i)         stat_q.err <= 1'b0;

      if (nack_i)       stat_q.nack <= 1'b1;
      else if (start_i) stat_q.nack <= 1'b0;

      if (arb_lost_i)   stat_q.arb_lost <= 1'b1;
      else if (start_i) stat_q.arb_lost <= 1'b0;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/i2c_slv_req.sv
module i2c_slv_req
  import i2c_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rx_req_i,
  input  logic    tx_req_i,
  input  logic    first_i,
  input  logic    data_rd_i,
  input  logic    data_wr_i,
  output s_stat_t stat_o
);

  s_stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      if (rx_req_i)       stat_q.rreq <= 1'b1;
      else if (data_rd_i) stat_q.rreq <= 1'b0;

      if (rx_req_i && first_i) stat_q.fbr <= 1'b1;
      else if (data_rd_i)      stat_q.fbr <= 1'b0;

      if (tx_req_i)       stat_q.treq <= 1'b1;
      else if (data_wr_i) stat_q.treq <= 1'b0;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 busy_i,
  input  m_stat_t              m_stat_i,
  input  s_stat_t              s_stat_i,
  input  logic [NUM_SIDES-1:0] raw_i,
  input  logic [NUM_SIDES-1:0] mask_i,
  input  logic [DATA_W-1:0]    rx_data_i,
  output logic [NUM_SIDES-1:0] clr_o,
  output logic [NUM_SIDES-1:0] mask_we_o,
  output logic                 data_rd_o,
  output logic                 data_wr_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic                 tx_load_o
);

  localparam int unsigned AW_REG = 4;

  logic              addr_hi_zero;
  logic [AW_REG-1:0] addr_lo;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, tx_data_q;
  logic              tx_load_q;

  generate
    if (ADDR_W > AW_REG) begin : g_hi
      assign addr_hi_zero = ~|addr_i[ADDR_W-1:AW_REG];
    end else begin : g_nohi
      assign addr_hi_zero = 1'b1;
    end
  endgenerate

  assign addr_lo = addr_i[AW_REG-1:0];
  assign wr      = req_i & we_i & addr_hi_zero;
  assign rd      = req_i & ~we_i;

  function automatic logic hit(input logic [AW_REG-1:0] a, input reg_addr_e r);
    return a == r;
  endfunction

  assign clr_o[SIDE_M]     = wr & hit(addr_lo, RA_MCLR) & wdata_i[0];
  assign clr_o[SIDE_S]     = wr & hit(addr_lo, RA_SCLR) & wdata_i[0];
  assign mask_we_o[SIDE_M] = wr & hit(addr_lo, RA_MMASK);
  assign mask_we_o[SIDE_S] = wr & hit(addr_lo, RA_SMASK);
  assign data_wr_o         = wr & hit(addr_lo, RA_SDATA);
  assign data_rd_o         = rd & addr_hi_zero & hit(addr_lo, RA_SDATA);

  always_comb begin
    rd_mux = '0;
    if (addr_hi_zero) begin
      case (addr_lo)
        RA_MSTAT: rd_mux = DATA_W'({m_stat_i, busy_i});
        RA_MMASK: rd_mux = DATA_W'(mask_i[SIDE_M]);
        RA_MRAW:  rd_mux = DATA_W'(raw_i[SIDE_M]);
        RA_SSTAT: rd_mux = DATA_W'(s_stat_i);
        RA_SMASK: rd_mux = DATA_W'(mask_i[SIDE_S]);
        RA_SRAW:  rd_mux = DATA_W'(raw_i[SIDE_S]);
        RA_SDATA: rd_mux = rx_data_i;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      tx_data_q <= '0;
      tx_load_q <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      if (data_wr_o) tx_data_q <= wdata_i;
      tx_load_q <= data_wr_o;
    end
  end

  assign rdata_o   = rdata_q;
  assign tx_data_o = tx_data_q;
  assign tx_load_o = tx_load_q;

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              m_busy_i,
  input  logic              m_start_i,
  input  logic              m_done_i,
  input  logic              m_nack_i,
  input  logic              m_arb_lost_i,
  input  logic              s_rx_req_i,
  input  logic              s_tx_req_i,
  input  logic              s_first_byte_i,
  input  logic [DATA_W-1:0] s_rx_data_i,
  output logic [DATA_W-1:0] s_tx_data_o,
  output logic              s_tx_load_o,
  output logic              m_irq_o,
  output logic              s_irq_o
);

  logic [NUM_SIDES-1:0] side_evt, side_clr, side_mwe;
  logic [NUM_SIDES-1:0] side_raw, side_mask, side_irq;
  m_stat_t              m_stat;
  s_stat_t              s_stat;
  logic                 data_rd, data_wr;

  assign side_evt[SIDE_M] = m_done_i | m_nack_i | m_arb_lost_i;
  assign side_evt[SIDE_S] = s_rx_req_i | s_tx_req_i;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    i2c_irq_line u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (side_evt[g]),
      .clr_i    (side_clr[g]),
      .mask_we_i(side_mwe[g]),
      .mask_d_i (wdata_i[0]),
      .raw_o    (side_raw[g]),
      .mask_o   (side_mask[g]),
      .irq_o    (side_irq[g])
    );
  end

  i2c_mst_err u_mst_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nack_i    (m_nack_i),
    .arb_lost_i(m_arb_lost_i),
    .start_i   (m_start_i),
    .stat_o    (m_stat)
  );

  i2c_slv_req u_slv_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_req_i (s_rx_req_i),
    .tx_req_i (s_tx_req_i),
    .first_i  (s_first_byte_i),
    .data_rd_i(data_rd),
    .data_wr_i(data_wr),
    .stat_o   (s_stat)
  );

  i2c_irq_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .busy_i   (m_busy_i),
    .m_stat_i (m_stat),
    .s_stat_i (s_stat),
    .raw_i    (side_raw),
    .mask_i   (side_mask),
    .rx_data_i(s_rx_data_i),
    .clr_o    (side_clr),
    .mask_we_o(side_mwe),
    .data_rd_o(data_rd),
    .data_wr_o(data_wr),
    .rdata_o  (rdata_o),
    .tx_data_o(s_tx_data_o),
    .tx_load_o(s_tx_load_o)
  );

  assign m_irq_o = side_irq[SIDE_M];
  assign s_irq_o = side_irq[SIDE_S];

endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              m_done_i,
  input logic              m_nack_i,
  input logic              m_arb_lost_i,
  input logic              m_start_i,
  input logic              s_rx_req_i,
  input logic              s_tx_req_i,
  input logic              m_irq_o,
  input logic              s_irq_o,
  input logic              m_raw,
  input logic              m_mask,
  input logic              s_raw,
  input logic              m_err,
  input logic              s_rreq,
  input logic              s_fbr
);

  logic m_ev, s_ev, m_clr1, smask_wr;
  assign m_ev     = m_done_i | m_nack_i | m_arb_lost_i;
  assign s_ev     = s_rx_req_i | s_tx_req_i;
  assign m_clr1   = req_i & we_i & (addr_i == ADDR_W'(3)) & wdata_i[0];
  assign smask_wr = req_i & we_i & (addr_i == ADDR_W'(5));

  // R2 R7
  m_evt_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_ev |=> m_raw);

  // R7
  s_evt_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ev |=> s_raw);

  // R6
  m_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_clr1 && !m_ev) |=> !m_raw);

  // R3
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_nack_i || m_arb_lost_i) |=> m_err);

  // R3
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(m_err) |-> $past(m_start_i));

  // R8
  fbr_rreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_fbr |-> s_rreq);

  // R4
  m_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_irq_o |-> (m_mask && m_raw));

  // R10
  s_irq_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s_irq_o) |-> $past(s_ev || smask_wr));

endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .m_done_i    (m_done_i),
  .m_nack_i    (m_nack_i),
  .m_arb_lost_i(m_arb_lost_i),
  .m_start_i   (m_start_i),
  .s_rx_req_i  (s_rx_req_i),
  .s_tx_req_i  (s_tx_req_i),
  .m_irq_o     (m_irq_o),
  .s_irq_o     (s_irq_o),
  .m_raw       (side_raw[0]),
  .m_mask      (side_mask[0]),
  .s_raw       (side_raw[1]),
  .m_err       (m_stat.err),
  .s_rreq      (s_stat.rreq),
  .s_fbr       (s_stat.fbr)
);

// File: tb/tb_i2c_irq_unit.sv
`timescale 1ns/1ps
module tb_i2c_irq_unit;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata_o, s_tx_data_o;
  logic              m_busy = 0, m_start = 0, m_done = 0, m_nack = 0, m_arb = 0;
  logic              s_rx = 0, s_tx = 0, s_first = 0;
  logic [DATA_W-1:0] s_rx_data = '0;
  logic              s_tx_load_o, m_irq_o, s_irq_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  bit md_mraw, md_mmask, md_err, md_nack, md_arb;
  bit md_sraw, md_smask, md_rreq, md_treq, md_fbr;

  always #2.5 clk = ~clk;

  i2c_irq_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .m_busy_i(m_busy), .m_start_i(m_start),
    .m_done_i(m_done), .m_nack_i(m_nack), .m_arb_lost_i(m_arb),
    .s_rx_req_i(s_rx), .s_tx_req_i(s_tx), .s_first_byte_i(s_first),
    .s_rx_data_i(s_rx_data), .s_tx_data_o(s_tx_data_o), .s_tx_load_o(s_tx_load_o),
    .m_irq_o(m_irq_o), .s_irq_o(s_irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_read(input logic [ADDR_W-1:0] a);
    case (a)
      0: return DATA_W'({md_arb, md_nack, md_err, m_busy});
      1: return DATA_W'(md_mmask);
      2: return DATA_W'(md_mraw);
      4: return DATA_W'({md_fbr, md_treq, md_rreq});
      5: return DATA_W'(md_smask);
      6: return DATA_W'(md_sraw);
      8: return s_rx_data;
      default: return '0;
    endcase
  endfunction

  function automatic void model_step();
    bit wr = req && we;
    bit rd = req && !we;
    bit m_ev = m_done || m_nack || m_arb;
    bit s_ev = s_rx || s_tx;
    if (m_ev) md_mraw = 1; else if (wr && addr == 3 && wdata[0]) md_mraw = 0;
    if (s_ev) md_sraw = 1; else if (wr && addr == 7 && wdata[0]) md_sraw = 0;
    if (wr && addr == 1) md_mmask = wdata[0];
    if (wr && addr == 5) md_smask = wdata[0];
    if (m_nack || m_arb) md_err = 1; else if (m_start) md_err = 0;
    if (m_nack) md_nack = 1; else if (m_start) md_nack = 0;
    if (m_arb) md_arb = 1; else if (m_start) md_arb = 0;
    if (s_rx) md_rreq = 1; else if (rd && addr == 8) md_rreq = 0;
    if (s_rx && s_first) md_fbr = 1; else if (rd && addr == 8) md_fbr = 0;
    if (s_tx) md_treq = 1; else if (wr && addr == 8) md_treq = 0;
  endfunction

  task automatic tick();
    logic [DATA_W-1:0] e_rd;
    bit rd_now, wr8;
    @(posedge clk); #1;
    rd_now = req && !we;
    wr8    = req && we && addr == 8;
    e_rd   = model_read(addr);
    model_step();
    chk(m_irq_o == (md_mraw & md_mmask), "R4 m_irq_o", m_irq_o, md_mraw & md_mmask);
    chk(s_irq_o == (md_sraw & md_smask), "R4 s_irq_o", s_irq_o, md_sraw & md_smask);
    if (rd_now) chk(rdata_o == e_rd, "R11 rdata model", rdata_o, e_rd);
    chk(s_tx_load_o == wr8, "R9 tx_load", s_tx_load_o, wr8);
    if (wr8) chk(s_tx_data_o == wdata, "R9 tx_data", s_tx_data_o, wdata);
    @(negedge clk);
    req = 0; we = 0; m_start = 0; m_done = 0; m_nack = 0; m_arb = 0;
    s_rx = 0; s_tx = 0; s_first = 0;
  endtask

  task automatic wr_reg(input int a, input int d);
    req = 1; we = 1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    tick();
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    req = 1; we = 0; addr = ADDR_W'(a);
    tick();
    chk(rdata_o == DATA_W'(exp), tag, rdata_o, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_1C2A));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(m_irq_o == 0, "R1 m_irq_o reset", m_irq_o, 0);
    chk(s_irq_o == 0, "R1 s_irq_o reset", s_irq_o, 0);
    rst_ni = 1;
    @(negedge clk);
    for (int a = 0; a < 10; a++) rd_exp(a, 0, "R1 reg reset");

    // R2 R5: event with mask off
    m_done = 1; tick();
    rd_exp(2, 1, "R5 mraw visible masked");
    chk(m_irq_o == 0, "R4 masked m_irq", m_irq_o, 0);
    wr_reg(1, 1);
    chk(m_irq_o == 1, "R4 unmasked m_irq", m_irq_o, 1);
    rd_exp(1, 1, "R4 mmask readback");
    // R6 write 0 keeps, write 1 clears
    wr_reg(3, 8'hFE);
    rd_exp(2, 1, "R6 write0 no effect");
    wr_reg(3, 1);
    rd_exp(2, 0, "R6 w1c master");
    chk(m_irq_o == 0, "R6 m_irq after clear", m_irq_o, 0);
    // R7 event vs clear
    m_arb = 1; req = 1; we = 1; addr = 3; wdata = 1; tick();
    rd_exp(2, 1, "R7 event wins");
    // R3 error bookkeeping
    m_start = 1; tick();
    rd_exp(0, 0, "R3 start clears");
    m_nack = 1; tick();
    m_done = 1; tick();
    rd_exp(0, 6, "R3 nack err held");
    m_busy = 1;
    rd_exp(0, 7, "R3 busy bit");
    m_busy = 0;
    m_start = 1; m_arb = 1; tick();
    rd_exp(0, 8'hA, "R3 arb wins over start");
    m_start = 1; tick();
    wr_reg(3, 1);
    // R10 isolation
    wr_reg(5, 1);
    m_done = 1; tick();
    chk(s_irq_o == 0, "R10 master evt no s_irq", s_irq_o, 0);
    rd_exp(6, 0, "R10 sraw untouched");
    wr_reg(3, 1);
    s_tx = 1; tick();
    chk(m_irq_o == 0, "R10 slave evt no m_irq", m_irq_o, 0);
    chk(s_irq_o == 1, "R10 s_irq set", s_irq_o, 1);
    // R8 R9
    rd_exp(4, 2, "R8 treq");
    wr_reg(8, 8'h3C);
    chk(s_tx_data_o == 8'h3C, "R9 tx data held", s_tx_data_o, 8'h3C);
    rd_exp(4, 0, "R9 treq cleared");
    s_rx = 1; s_first = 1; s_rx_data = 8'hA5; tick();
    rd_exp(4, 5, "R8 rreq fbr together");
    rd_exp(8, 8'hA5, "R9 sdata read");
    rd_exp(4, 0, "R9 rreq fbr cleared");
    s_rx = 1; req = 1; we = 0; addr = 8; tick();
    rd_exp(4, 1, "R9 rx event wins over read");
    wr_reg(7, 1);
    rd_exp(6, 0, "R6 w1c slave");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      m_busy    = ($urandom_range(0, 3) == 0);
      m_start   = ($urandom_range(0, 15) == 0);
      m_done    = ($urandom_range(0, 11) == 0);
      m_nack    = ($urandom_range(0, 23) == 0);
      m_arb     = ($urandom_range(0, 23) == 0);
      s_rx      = ($urandom_range(0, 11) == 0);
      s_first   = s_rx && ($urandom_range(0, 1) == 0);
      s_tx      = ($urandom_range(0, 11) == 0);
      s_rx_data = DATA_W'($urandom);
      req       = ($urandom_range(0, 1) == 0);
      we        = ($urandom_range(0, 1) == 0);
      addr      = ADDR_W'($urandom_range(0, 9));
      wdata     = DATA_W'($urandom);
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog timeout act=%0d exp=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule